// File: doc/BRIEF.md
# Longest-Prefix Forwarding Table with Adjacency Classes

This block is a small forwarding table for IPv4 destinations. A control processor fills its slots through a one-entry-at-a-time write port. Each slot holds a valid flag, a prefix, a mask length, an adjacency class and an adjacency index. A lookup compares the destination address against all slots in parallel. The matching slot with the longest mask is chosen, and its class and index are returned. If no slot matches, the result is a definite miss. There is no secondary cache and no slower path to fall back on, so a miss means the packet is discarded.

The adjacency class tells the rest of the datapath what to do with a hit:
- **next hop** (0): forward to a neighbour.
- **attached** (1): the destination is on a directly attached subnet.
- **receive** (2): the packet is for the router itself. This class is used for host routes to the router's own addresses and for a subnet's network and broadcast addresses.
- **drop** (3): discard the packet, for example a blocked range.

The lookup runs in two pipeline stages. The first stage compares and snapshots the table. The second stage reduces the matches by mask length. A new lookup can be accepted every cycle.

Top module: `fib_lookup`

## Requirements
- R1: On a hit, `res_class_o` returns the winning slot's class (0 next hop, 1 attached, 2 receive, 3 drop) and `res_adj_o` returns its adjacency index.
- R2: When several valid slots match, the slot with the greatest mask length wins.
- R3: When matching slots have equal mask length, the lowest slot number wins.
- R4: A lookup that matches no valid slot yields `res_hit_o`=0, `res_class_o`=0 and `res_adj_o`=0.
- R5: A slot with mask length 0 matches every address. It is chosen only when no longer prefix matches.
- R6: A slot whose valid flag is 0 never matches, whatever its prefix and length hold. Writing a slot with `wr_valid_i`=0 removes it.
- R7: For each lookup accepted (`lk_valid_i` and `lk_ready_o` high at a clock edge), `res_valid_o` is high for exactly one cycle, two clock edges later. Back-to-back lookups give results on consecutive cycles.
- R8: A lookup accepted at the edge after a write's edge still sees the old slot contents. A lookup accepted two or more edges after the write sees the new contents.
- R9: `lk_ready_o` is 0 in reset, rises at the first edge after reset and then stays 1. Cycles with `lk_valid_i`=0 produce no result.
- R10: A /32 slot matches only its exact address. It overrides a covering /24 for that address, while neighbouring addresses keep the /24 result.
- R11: A /4 drop slot and a /24 receive slot nested inside it coexist. Addresses inside the /24 return receive; other addresses in the /4 return drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write one table slot |
| wr_slot_i | input | 4 | Slot number to write |
| wr_valid_i | input | 1 | Valid flag for the written slot |
| wr_prefix_i | input | 32 | Prefix value |
| wr_len_i | input | 6 | Mask length, 0 to 32 |
| wr_class_i | input | 2 | Adjacency class |
| wr_adj_i | input | 4 | Adjacency index |
| lk_valid_i | input | 1 | Lookup request |
| lk_ready_o | output | 1 | Lookup can be accepted |
| lk_addr_i | input | 32 | Destination address |
| res_valid_o | output | 1 | Result valid |
| res_hit_o | output | 1 | Some valid slot matched |
| res_class_o | output | 2 | Winning adjacency class |
| res_adj_o | output | 4 | Winning adjacency index |

## Verification
The hardest case to reach is the race between a table write and lookups in flight. The write is first captured and only committed one edge later. Meanwhile the second pipeline stage works on a snapshot of the table.

The stimulus issues a write and presents lookups for the same address in the very next cycle and in the cycle after that. It expects the old default route first and the new entry second.

Nested prefixes, equal-length ties and an invalidated slot are loaded together, so that the reduction must choose among several simultaneous matches.

// File: rtl/fib_pkg.sv
package fib_pkg;
  typedef enum logic [1:0] {
    ADJ_NEXT_HOP = 2'd0,
    ADJ_ATTACHED = 2'd1,
    ADJ_RECEIVE  = 2'd2,
    ADJ_DROP     = 2'd3
  } adj_class_e;
endpackage

// File: rtl/fib_table.sv
module fib_table
  import fib_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 6,
  parameter int ADJ_W     = 4,
  localparam int SLOT_W   = $clog2(N_ENTRIES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [SLOT_W-1:0]     wr_slot_i,
  input  logic                  wr_valid_i,
  input  logic [ADDR_W-1:0]     wr_prefix_i,
  input  logic [LEN_W-1:0]      wr_len_i,
  input  adj_class_e            wr_class_i,
  input  logic [ADJ_W-1:0]      wr_adj_i,
  output logic [N_ENTRIES-1:0]  ent_valid_o,
  output logic [ADDR_W-1:0]     ent_prefix_o [N_ENTRIES],
  output logic [LEN_W-1:0]      ent_len_o    [N_ENTRIES],
  output adj_class_e            ent_class_o  [N_ENTRIES],
  output logic [ADJ_W-1:0]      ent_adj_o    [N_ENTRIES]
);
  // write capture stage: commit happens one edge after capture
  logic              pend_q;
  logic [SLOT_W-1:0] pend_slot_q;
  logic              pend_valid_q;
  logic [ADDR_W-1:0] pend_prefix_q;
  logic [LEN_W-1:0]  pend_len_q;
  adj_class_e        pend_class_q;
  logic [ADJ_W-1:0]  pend_adj_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q        <= 1'b0;
      pend_slot_q   <= '0;
      pend_valid_q  <= 1'b0;
      pend_prefix_q <= '0;
      pend_len_q    <= '0;
      pend_class_q  <= ADJ_NEXT_HOP;
      pend_adj_q    <= '0;
    end else begin
      pend_q <= wr_en_i;
      if (wr_en_i) begin
        pend_slot_q   <= wr_slot_i;
        pend_valid_q  <= wr_valid_i;
        pend_prefix_q <= wr_prefix_i;
        pend_len_q    <= wr_len_i;
        pend_class_q  <= wr_class_i;
        pend_adj_q    <= wr_adj_i;
      end
    end
  end

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_slot
    logic hit_slot;
    assign hit_slot = pend_q && (pend_slot_q == SLOT_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_valid_o[i]  <= 1'b0;
        ent_prefix_o[i] <= '0;
        ent_len_o[i]    <= '0;
        ent_class_o[i]  <= ADJ_NEXT_HOP;
        ent_adj_o[i]    <= '0;
      end else if (hit_slot) begin
        ent_valid_o[i]  <= pend_valid_q;
        ent_prefix_o[i] <= pend_prefix_q;
        ent_len_o[i]    <= pend_len_q;
        ent_class_o[i]  <= pend_class_q;
        ent_adj_o[i]    <= pend_adj_q;
      end
    end
  end

  // R8
  commit_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> $past(wr_en_i));
endmodule

// File: rtl/fib_match.sv
module fib_match #(
  parameter int N_ENTRIES = 16,
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 6
) (
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [N_ENTRIES-1:0] ent_valid_i,
  input  logic [ADDR_W-1:0]    ent_prefix_i [N_ENTRIES],
  input  logic [LEN_W-1:0]     ent_len_i    [N_ENTRIES],
  output logic [N_ENTRIES-1:0] match_o
);
  function automatic logic [ADDR_W-1:0] len_mask(input logic [LEN_W-1:0] len);
    logic [ADDR_W-1:0] m;
    for (int b = 0; b < ADDR_W; b++) m[b] = ((ADDR_W - 1 - b) < int'(len));
    return m;
  endfunction

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_cmp
    assign match_o[i] = ent_valid_i[i] &&
      (((addr_i ^ ent_prefix_i[i]) & len_mask(ent_len_i[i])) == '0);
  end
endmodule

// File: rtl/fib_select.sv
module fib_select
  import fib_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int LEN_W     = 6,
  parameter int ADJ_W     = 4
) (
  input  logic [N_ENTRIES-1:0] match_i,
  input  logic [LEN_W-1:0]     len_i   [N_ENTRIES],
  input  adj_class_e           class_i [N_ENTRIES],
  input  logic [ADJ_W-1:0]     adj_i   [N_ENTRIES],
  output logic                 hit_o,
  output adj_class_e           class_o,
  output logic [ADJ_W-1:0]     adj_o
);
  logic [LEN_W-1:0] best_len;

  // walk from the top slot down; ">=" lets the lower slot take ties
  always_comb begin
    hit_o    = 1'b0;
    class_o  = ADJ_NEXT_HOP;
    adj_o    = '0;
    best_len = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (match_i[i] && (!hit_o || len_i[i] >= best_len)) begin
        hit_o    = 1'b1;
        best_len = len_i[i];
        class_o  = class_i[i];
        adj_o    = adj_i[i];
      end
    end
  end
endmodule

// File: rtl/fib_lookup.sv
module fib_lookup
  import fib_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int ADDR_W    = 32,
  parameter int ADJ_W     = 4,
  localparam int SLOT_W   = $clog2(N_ENTRIES),
  localparam int LEN_W    = $clog2(ADDR_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_prefix_i,
  input  logic [LEN_W-1:0]  wr_len_i,
  input  logic [1:0]        wr_class_i,
  input  logic [ADJ_W-1:0]  wr_adj_i,
  input  logic              lk_valid_i,
  output logic              lk_ready_o,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic              res_valid_o,
  output logic              res_hit_o,
  output logic [1:0]        res_class_o,
  output logic [ADJ_W-1:0]  res_adj_o
);
  logic [N_ENTRIES-1:0] tbl_valid;
  logic [ADDR_W-1:0]    tbl_prefix [N_ENTRIES];
  logic [LEN_W-1:0]     tbl_len    [N_ENTRIES];
  adj_class_e           tbl_class  [N_ENTRIES];
  logic [ADJ_W-1:0]     tbl_adj    [N_ENTRIES];

  fib_table #(.N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .ADJ_W(ADJ_W)) u_table (
    .clk_i, .rst_ni, .wr_en_i, .wr_slot_i, .wr_valid_i, .wr_prefix_i, .wr_len_i,
    .wr_class_i  (adj_class_e'(wr_class_i)),
    .wr_adj_i,
    .ent_valid_o (tbl_valid),
    .ent_prefix_o(tbl_prefix),
    .ent_len_o   (tbl_len),
    .ent_class_o (tbl_class),
    .ent_adj_o   (tbl_adj)
  );

  logic [N_ENTRIES-1:0] cmp_match;
  fib_match #(.N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_match (
    .addr_i      (lk_addr_i),
    .ent_valid_i (tbl_valid),
    .ent_prefix_i(tbl_prefix),
    .ent_len_i   (tbl_len),
    .match_o     (cmp_match)
  );

  logic ready_q;
  logic accept;
  assign lk_ready_o = ready_q;
  assign accept     = lk_valid_i && ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ready_q <= 1'b0;
    else         ready_q <= 1'b1;
  end

  // stage 1: match vector plus snapshot of the fields the reduction needs
  logic                 s1_valid_q;
  logic [N_ENTRIES-1:0] s1_match_q;
  logic [LEN_W-1:0]     s1_len_q   [N_ENTRIES];
  adj_class_e           s1_class_q [N_ENTRIES];
  logic [ADJ_W-1:0]     s1_adj_q   [N_ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q <= 1'b0;
      s1_match_q <= '0;
    end else begin
      s1_valid_q <= accept;
      if (accept) s1_match_q <= cmp_match;
    end
  end

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_snap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_len_q[i]   <= '0;
        s1_class_q[i] <= ADJ_NEXT_HOP;
        s1_adj_q[i]   <= '0;
      end else if (accept) begin
        s1_len_q[i]   <= tbl_len[i];
        s1_class_q[i] <= tbl_class[i];
        s1_adj_q[i]   <= tbl_adj[i];
      end
    end

    // R6
    entry_invalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (accept && !tbl_valid[i]) |=> !s1_match_q[i]);
  end

  logic             sel_hit;
  adj_class_e       sel_class;
  logic [ADJ_W-1:0] sel_adj;

  fib_select #(.N_ENTRIES(N_ENTRIES), .LEN_W(LEN_W), .ADJ_W(ADJ_W)) u_select (
    .match_i (s1_match_q),
    .len_i   (s1_len_q),
    .class_i (s1_class_q),
    .adj_i   (s1_adj_q),
    .hit_o   (sel_hit),
    .class_o (sel_class),
    .adj_o   (sel_adj)
  );

  // stage 2: registered result
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_hit_o   <= 1'b0;
      res_class_o <= '0;
      res_adj_o   <= '0;
    end else begin
      res_valid_o <= s1_valid_q;
      if (s1_valid_q) begin
        res_hit_o   <= sel_hit;
        res_class_o <= sel_class;
        res_adj_o   <= sel_adj;
      end
    end
  end

  // R7
  result_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o == $past(lk_valid_i && lk_ready_o, 2));

  // R4
  miss_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_hit_o) |-> (res_class_o == 2'd0 && res_adj_o == '0));

  // R9
  ready_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_ready_o |=> lk_ready_o);
endmodule

// File: tb/tb_fib_lookup.sv
module tb_fib_lookup;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_slot_i = '0;
  logic        wr_valid_i = 1'b0;
  logic [31:0] wr_prefix_i = '0;
  logic [5:0]  wr_len_i = '0;
  logic [1:0]  wr_class_i = '0;
  logic [3:0]  wr_adj_i = '0;
  logic        lk_valid_i = 1'b0;
  logic        lk_ready_o;
  logic [31:0] lk_addr_i = '0;
  logic        res_valid_o, res_hit_o;
  logic [1:0]  res_class_o;
  logic [3:0]  res_adj_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  fib_lookup dut (
    .clk_i(clk), .rst_ni, .wr_en_i, .wr_slot_i, .wr_valid_i, .wr_prefix_i,
    .wr_len_i, .wr_class_i, .wr_adj_i, .lk_valid_i, .lk_ready_o, .lk_addr_i,
    .res_valid_o, .res_hit_o, .res_class_o, .res_adj_o
  );

  localparam logic [1:0] NH = 2'd0, AT = 2'd1, RX = 2'd2, DR = 2'd3;

  function automatic logic [31:0] ip(input int a, input int b, input int c, input int d);
    return {a[7:0], b[7:0], c[7:0], d[7:0]};
  endfunction

  task automatic check_bit(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic check_res(input string req, input logic hit, input logic [1:0] cls,
                           input logic [3:0] adj);
    n_chk++;
    if (res_valid_o !== 1'b1 || res_hit_o !== hit || res_class_o !== cls || res_adj_o !== adj) begin
      n_fail++;
      $display("FAIL %s: got v=%0b h=%0b c=%0d a=%0d expected v=1 h=%0b c=%0d a=%0d",
               req, res_valid_o, res_hit_o, res_class_o, res_adj_o, hit, cls, adj);
    end
  endtask

  task automatic wr(input int slot, input logic v, input logic [31:0] pfx, input int len,
                    input logic [1:0] cls, input int adj);
    @(negedge clk);
    wr_en_i = 1'b1; wr_slot_i = slot[3:0]; wr_valid_i = v; wr_prefix_i = pfx;
    wr_len_i = len[5:0]; wr_class_i = cls; wr_adj_i = adj[3:0];
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic lookup(input string req, input logic [31:0] a, input logic hit,
                        input logic [1:0] cls, input int adj);
    @(negedge clk);
    lk_valid_i = 1'b1; lk_addr_i = a;
    @(negedge clk);
    lk_valid_i = 1'b0;
    @(negedge clk);
    check_res(req, hit, cls, adj[3:0]);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check_bit("R9 ready low in reset", lk_ready_o, 1'b0);
    check_bit("R7 no result in reset", res_valid_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk);
    check_bit("R9 ready after reset", lk_ready_o, 1'b1);
  endtask

  task automatic t_empty_miss;
    lookup("R4 empty table miss", ip(8,8,8,8), 1'b0, 2'd0, 0);
  endtask

  task automatic t_load;
    wr(0, 1, ip(0,0,0,0), 0, NH, 1);
    wr(1, 1, ip(10,0,0,0), 8, NH, 2);
    wr(2, 1, ip(10,82,69,0), 24, AT, 3);
    wr(3, 1, ip(10,82,69,121), 32, RX, 0);
    wr(4, 1, ip(224,0,0,0), 4, DR, 0);
    wr(5, 1, ip(224,0,0,0), 24, RX, 0);
    wr(6, 1, ip(192,168,100,0), 24, NH, 5);
    wr(7, 1, ip(192,168,100,0), 24, AT, 6);
    wr(8, 0, ip(172,12,12,0), 24, AT, 7);
    wr(15, 1, ip(172,0,0,0), 30, AT, 15);
  endtask

  task automatic t_longest;
    lookup("R5 default route", ip(8,8,8,8), 1'b1, NH, 1);
    lookup("R2 /8 beats /0", ip(10,1,2,3), 1'b1, NH, 2);
    lookup("R2 /24 beats /8", ip(10,82,69,7), 1'b1, AT, 3);
    lookup("R10 /32 receive host", ip(10,82,69,121), 1'b1, RX, 0);
    lookup("R10 neighbour keeps /24", ip(10,82,69,120), 1'b1, AT, 3);
    lookup("R1 high slot attached /30", ip(172,0,0,2), 1'b1, AT, 15);
  endtask

  task automatic t_nested_drop;
    lookup("R11 receive inside drop", ip(224,0,0,5), 1'b1, RX, 0);
    lookup("R11 drop elsewhere in /4", ip(239,1,1,1), 1'b1, DR, 0);
  endtask

  task automatic t_tie;
    lookup("R3 tie lowest slot", ip(192,168,100,9), 1'b1, NH, 5);
  endtask

  task automatic t_invalid;
    lookup("R6 invalid slot ignored", ip(172,12,12,5), 1'b1, NH, 1);
    wr(6, 0, ip(192,168,100,0), 24, NH, 5);
    lookup("R6 cleared slot removed", ip(192,168,100,9), 1'b1, AT, 6);
  endtask

  task automatic t_write_race;
    @(negedge clk);
    wr_en_i = 1'b1; wr_slot_i = 4'd9; wr_valid_i = 1'b1; wr_prefix_i = ip(8,8,8,0);
    wr_len_i = 6'd24; wr_class_i = DR; wr_adj_i = 4'd9;
    @(negedge clk);
    wr_en_i = 1'b0;
    lk_valid_i = 1'b1; lk_addr_i = ip(8,8,8,8);
    @(negedge clk);
    @(negedge clk);
    lk_valid_i = 1'b0;
    check_res("R8 next-cycle lookup sees old", 1'b1, NH, 4'd1);
    @(negedge clk);
    check_res("R8 two-cycle lookup sees new", 1'b1, DR, 4'd9);
  endtask

  task automatic t_pipeline;
    @(negedge clk);
    lk_valid_i = 1'b1; lk_addr_i = ip(10,9,9,9);
    @(negedge clk);
    lk_addr_i = ip(224,0,0,1);
    @(negedge clk);
    lk_addr_i = ip(9,9,9,9);
    check_res("R7 back-to-back first", 1'b1, NH, 4'd2);
    @(negedge clk);
    lk_valid_i = 1'b0;
    check_res("R7 back-to-back second", 1'b1, RX, 4'd0);
    @(negedge clk);
    check_res("R7 back-to-back third", 1'b1, NH, 4'd1);
    @(negedge clk);
    check_bit("R9 idle gives no result", res_valid_o, 1'b0);
  endtask

  task automatic t_final_miss;
    wr(0, 0, ip(0,0,0,0), 0, NH, 1);
    lookup("R4 miss after default removed", ip(9,9,9,9), 1'b0, 2'd0, 0);
    lookup("R1 drop class still hits", ip(8,8,8,1), 1'b1, DR, 9);
  endtask

  initial begin
    t_reset();
    t_empty_miss();
    t_load();
    t_longest();
    t_nested_drop();
    t_tie();
    t_invalid();
    t_write_race();
    t_pipeline();
    t_final_miss();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule